// File: doc/BRIEF.md
# Serial Tuning Word Loader for a Direct Digital Synthesizer

This block loads a 40-bit tuning word into a direct digital synthesizer whose mode pins are strapped for serial loading. A request on a valid/ready interface carries a 32-bit frequency value and an 8-bit control byte. The block moves that word onto a single data line, one bit per pulse of a bit clock that it generates. It then pulses a separate word clock, which commits the shifted word to the device's active frequency register.

Right after reset, the block issues one word-clock pulse on its own. This pulse switches the device into serial mode. Until it is done, the block will not take any request.

The high and low times of the bit clock, the data setup time and the width of the word-clock pulse are each a count of system clocks set by a parameter. A further parameter reverses the bit order inside each field, so either shifting convention can be used.

Top module: `dds_serial_loader`

## Requirements
- R1: After reset the block issues exactly one word-clock pulse, high for WCLK_HI system clocks (default 3). No bit-clock edge comes before it. The ready output stays low until that pulse has ended.
- R2: The busy output is always the inverse of req_ready. A request is taken on a rising system-clock edge where req_valid and req_ready are both high.
- R3: Each request is sent as 40 bits in a fixed order. With MSB_FIRST=0 (default), send position i carries req_freq[i] for i = 0..31, then req_ctrl[i-32] for i = 32..39. With MSB_FIRST=1 the order inside each field is reversed, and the frequency field still goes first.
- R4: Each request produces exactly 40 rising edges of bit_clk. Each high phase of bit_clk lasts BCLK_HI system clocks (default 2).
- R5: ser_data is stable for at least SETUP_CYC system clocks (default 1) before each rising edge of bit_clk. It does not change in the cycle in which bit_clk falls.
- R6: After the 40th bit, and only once bit_clk is low again, word_clk goes high for WCLK_HI system clocks. There is exactly one such pulse per request.
- R7: req_ready stays low for the whole transfer, including the word-clock pulse. A req_valid raised while ready is low is ignored: no extra bits and no extra pulse follow, and the bits sent are those of the request that was taken.
- R8: bit_clk and word_clk are low whenever the block is idle, and they are never high at the same time.
- R9: req_ready rises exactly one system clock after word_clk falls at the end of a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request holds a word to load |
| req_ready | output | 1 | Block is idle and will take a request |
| req_freq | input | 32 | Frequency tuning value |
| req_ctrl | input | 8 | Control byte |
| busy | output | 1 | Transfer or mode-enable pulse in progress |
| ser_data | output | 1 | Serial data line to the device |
| bit_clk | output | 1 | Per-bit shift clock to the device |
| word_clk | output | 1 | Word-latch strobe, also used once to enable serial mode |

## Verification
The word patterns are chosen so that every ordering mistake shows up as a mismatch:
- An all-ones word and an all-zeros word.
- A single set bit at the first send position, and a single set bit at the last.
- A word that is symmetric by bytes and by bits. It checks that the bit counter neither drops nor adds a position, since ordering errors cannot move its bits.
- Asymmetric mixed words. These separate "frequency first, LSB first" from byte-swapped or bit-reversed orders.

Further tests cover a request raised while busy, which must leave the sent bits and the pulse count unchanged, and requests held back to back. Timing checks measure the bit-clock high width, the data setup and hold around each edge, the word-clock width, and the one-cycle return of ready.

// File: rtl/dds_ld_pkg.sv
package dds_ld_pkg;

    typedef enum logic [2:0] {
        IDLE,
        ENABLE_PULSE,
        SHIFT_SETUP,
        SHIFT_HIGH,
        SHIFT_LOW,
        LATCH_PULSE,
        DONE
    } ld_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dds_ld_order.sv
// Maps frequency and control fields into send order: bit i of ordered_o
// is the i-th bit to leave on the serial line.
module dds_ld_order #(
    parameter int FREQ_W    = 32,
    parameter int CTRL_W    = 8,
    parameter bit MSB_FIRST = 1'b0,
    localparam int WORD_W   = FREQ_W + CTRL_W
) (
    input  logic [FREQ_W-1:0] freq_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [WORD_W-1:0] ordered_o
);

    generate
        for (genvar i = 0; i < FREQ_W; i++) begin : g_freq
            if (MSB_FIRST) begin : g_rev
                assign ordered_o[i] = freq_i[FREQ_W-1-i];
            end else begin : g_fwd
                assign ordered_o[i] = freq_i[i];
            end
        end
        for (genvar j = 0; j < CTRL_W; j++) begin : g_ctrl
            if (MSB_FIRST) begin : g_rev
                assign ordered_o[FREQ_W+j] = ctrl_i[CTRL_W-1-j];
            end else begin : g_fwd
                assign ordered_o[FREQ_W+j] = ctrl_i[j];
            end
        end
    endgenerate

endmodule

// File: rtl/dds_ld_fsm.sv
module dds_ld_fsm
    import dds_ld_pkg::*;
#(
    parameter int WORD_W    = 40,
    parameter int BCLK_HI   = 2,
    parameter int BCLK_LO   = 2,
    parameter int SETUP_CYC = 1,
    parameter int WCLK_HI   = 3,
    localparam int TMR_MAX  = max3(BCLK_HI, BCLK_LO, max3(SETUP_CYC, WCLK_HI, 1)),
    localparam int TW       = $clog2(TMR_MAX + 1),
    localparam int CW       = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] ordered_i,
    output logic              ready_o,
    output logic              sdat_o,
    output logic              bclk_o,
    output logic              wclk_o
);

    localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] T_HI    = TW'(BCLK_HI - 1);
    localparam logic [TW-1:0] T_LO    = TW'(BCLK_LO - 1);
    localparam logic [TW-1:0] T_WCLK  = TW'(WCLK_HI - 1);
    localparam logic [TW-1:0] T_BOOT  = TW'(WCLK_HI);
    localparam logic [CW-1:0] LAST    = CW'(WORD_W - 1);

    typedef struct packed {
        ld_state_t         st;
        logic [TW-1:0]     tmr;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] word;
        logic              sdat;
        logic              bclk;
        logic              wclk;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ENABLE_PULSE: begin
                if (r_q.tmr == '0) begin
                    r_d.wclk = 1'b0;
                    r_d.st   = DONE;
                end else begin
                    r_d.wclk = 1'b1;
                    r_d.tmr  = r_q.tmr - 1'b1;
                end
            end
            IDLE: begin
                r_d.bclk = 1'b0;
                r_d.wclk = 1'b0;
                if (req_valid) begin
                    r_d.word = ordered_i;
                    r_d.sdat = ordered_i[0];
                    r_d.cnt  = '0;
                    r_d.tmr  = T_SETUP;
                    r_d.st   = SHIFT_SETUP;
                end
            end
            SHIFT_SETUP: begin
                if (r_q.tmr == '0) begin
                    r_d.bclk = 1'b1;
                    r_d.tmr  = T_HI;
                    r_d.st   = SHIFT_HIGH;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            SHIFT_HIGH: begin
                if (r_q.tmr == '0) begin
                    r_d.bclk = 1'b0;
                    r_d.tmr  = T_LO;
                    r_d.st   = SHIFT_LOW;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            SHIFT_LOW: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end else if (r_q.cnt == LAST) begin
                    r_d.wclk = 1'b1;
                    r_d.tmr  = T_WCLK;
                    r_d.st   = LATCH_PULSE;
                end else begin
                    r_d.cnt  = r_q.cnt + 1'b1;
                    r_d.sdat = r_q.word[r_q.cnt + 1'b1];
                    r_d.tmr  = T_SETUP;
                    r_d.st   = SHIFT_SETUP;
                end
            end
            LATCH_PULSE: begin
                if (r_q.tmr == '0) begin
                    r_d.wclk = 1'b0;
                    r_d.st   = DONE;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            DONE: begin
                r_d.st = IDLE;
            end
            default: begin
                r_d.st = IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ENABLE_PULSE;
            r_q.tmr  <= T_BOOT;
            r_q.cnt  <= '0;
            r_q.word <= '0;
            r_q.sdat <= 1'b0;
            r_q.bclk <= 1'b0;
            r_q.wclk <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o = (r_q.st == IDLE);
    assign sdat_o  = r_q.sdat;
    assign bclk_o  = r_q.bclk;
    assign wclk_o  = r_q.wclk;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!bclk_o && !wclk_o)); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_o && wclk_o)); // R8
    AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_o) |-> $stable(sdat_o)); // R5
    AST_HOLD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bclk_o) |-> $stable(sdat_o)); // R5
    AST_LATCH_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == LATCH_PULSE) |-> (r_q.cnt == LAST && !bclk_o)); // R6
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wclk_o |-> !ready_o); // R7
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> $stable(r_q.word)); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST); // R4

endmodule

// File: rtl/dds_serial_loader.sv
module dds_serial_loader #(
    parameter int FREQ_W    = 32,
    parameter int CTRL_W    = 8,
    parameter int BCLK_HI   = 2,
    parameter int BCLK_LO   = 2,
    parameter int SETUP_CYC = 1,
    parameter int WCLK_HI   = 3,
    parameter bit MSB_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FREQ_W-1:0] req_freq,
    input  logic [CTRL_W-1:0] req_ctrl,
    output logic              busy,
    output logic              ser_data,
    output logic              bit_clk,
    output logic              word_clk
);

    localparam int WORD_W = FREQ_W + CTRL_W;

    logic [WORD_W-1:0] ordered;

    dds_ld_order #(
        .FREQ_W   (FREQ_W),
        .CTRL_W   (CTRL_W),
        .MSB_FIRST(MSB_FIRST)
    ) u_order (
        .freq_i   (req_freq),
        .ctrl_i   (req_ctrl),
        .ordered_o(ordered)
    );

    dds_ld_fsm #(
        .WORD_W   (WORD_W),
        .BCLK_HI  (BCLK_HI),
        .BCLK_LO  (BCLK_LO),
        .SETUP_CYC(SETUP_CYC),
        .WCLK_HI  (WCLK_HI)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .ordered_i(ordered),
        .ready_o  (req_ready),
        .sdat_o   (ser_data),
        .bclk_o   (bit_clk),
        .wclk_o   (word_clk)
    );

    assign busy = !req_ready;

    AST_BUSY_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy != req_ready); // R2

endmodule

// File: tb/sim_dds_serial_loader.sv
`timescale 1ns/1ps
module sim_dds_serial_loader;

    localparam int WCLK_W = 3;
    localparam int BHI_W  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_freq = '0;
    logic [7:0]  req_ctrl = '0;
    logic        busy, ser_data, bit_clk, word_clk;

    always #2 clk = ~clk;

    dds_serial_loader u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_freq(req_freq), .req_ctrl(req_ctrl), .busy(busy),
        .ser_data(ser_data), .bit_clk(bit_clk), .word_clk(word_clk)
    );

    // Entries are {freq[31:0], ctrl[7:0]}.
    localparam logic [39:0] VEC [0:6] = '{
        40'h00_0018_0000,
        40'hFF_FFFF_FFFF,
        40'h00_0000_0000,
        40'h00_0000_0100,
        40'h00_0000_0080,
        40'h12_3456_789C,
        40'hA5_0F3C_96E1
    };

    // Monitor: single writer of all mon_* state.
    logic        pb = 1'b0, pw = 1'b0, pd = 1'b0;
    logic [39:0] mon_rx = '0, mon_latched = '0;
    int mon_nbits = 0, mon_pulses = 0, mon_wwidth = 0, mon_wcnt = 0;
    int mon_bhi = 0, mon_bad_bhi = 0, mon_bad_setup = 0, mon_bad_hold = 0;
    int mon_lag = 0, mon_last_lag = -1, mon_bad_ready = 0;
    bit mon_lagging = 0;
    logic mon_hold_bit = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_clk && !pb) begin
                mon_rx <= {ser_data, mon_rx[39:1]};
                mon_nbits <= mon_nbits + 1;
                mon_hold_bit <= ser_data;
                if (ser_data !== pd) mon_bad_setup <= mon_bad_setup + 1;
                mon_bhi <= 1;
            end else if (bit_clk) begin
                mon_bhi <= mon_bhi + 1;
            end
            if (!bit_clk && pb) begin
                if (mon_bhi != BHI_W) mon_bad_bhi <= mon_bad_bhi + 1;
                if (ser_data !== mon_hold_bit) mon_bad_hold <= mon_bad_hold + 1;
            end
            if (word_clk && !pw) begin
                mon_wcnt <= 1;
                mon_latched <= mon_rx;
            end else if (word_clk) begin
                mon_wcnt <= mon_wcnt + 1;
            end
            if (!word_clk && pw) begin
                mon_pulses <= mon_pulses + 1;
                mon_wwidth <= mon_wcnt;
                mon_lag <= 1;
                mon_lagging <= 1;
            end else if (mon_lagging) begin
                if (req_ready) begin
                    mon_last_lag <= mon_lag;
                    mon_lagging <= 0;
                end else begin
                    mon_lag <= mon_lag + 1;
                end
            end
            if ((bit_clk || word_clk) && req_ready) mon_bad_ready <= mon_bad_ready + 1;
            pb <= bit_clk; pw <= word_clk; pd <= ser_data;
        end
    end

    int checks = 0, failures = 0;
    bit wd_hit = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [39:0] send_order(input logic [31:0] f, input logic [7:0] c);
        logic [39:0] s;
        for (int i = 0; i < 32; i++) s[i] = f[i];
        for (int i = 0; i < 8; i++) s[32+i] = c[i];
        return s;
    endfunction

    task automatic wait_pulses(input int target);
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk); #1;
            if (mon_pulses >= target && req_ready) break;
        end
    endtask

    task automatic send(input logic [31:0] f, input logic [7:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_freq = f; req_ctrl = c;
        for (int n = 0; n < 4000; n++) begin
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_all();
        int p0, n0;
        // Reset state
        repeat (3) @(negedge clk);
        chk(!bit_clk && !word_clk, "R8", "outputs low in reset", {bit_clk, word_clk}, 0);
        chk(busy == !req_ready, "R2", "busy inverse in reset", busy, !req_ready);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!req_ready, "R1", "ready low during enable", req_ready, 0);
        wait_pulses(1);
        chk(mon_pulses == 1, "R1", "one enable pulse", mon_pulses, 1);
        chk(mon_wwidth == WCLK_W, "R1", "enable pulse width", mon_wwidth, WCLK_W);
        chk(mon_nbits == 0, "R1", "no bit clock before enable", mon_nbits, 0);
        chk(req_ready && !busy, "R2", "ready after enable", req_ready, 1);

        // Table of vectors
        foreach (VEC[k]) begin
            p0 = mon_pulses; n0 = mon_nbits;
            send(VEC[k][39:8], VEC[k][7:0]);
            wait_pulses(p0 + 1);
            chk(mon_nbits - n0 == 40, "R4", "bit clock edges", mon_nbits - n0, 40);
            chk(mon_latched == send_order(VEC[k][39:8], VEC[k][7:0]), "R3", "bit order",
                mon_latched, send_order(VEC[k][39:8], VEC[k][7:0]));
            chk(mon_pulses - p0 == 1, "R6", "latch pulse count", mon_pulses - p0, 1);
            chk(mon_wwidth == WCLK_W, "R6", "latch pulse width", mon_wwidth, WCLK_W);
            chk(mon_last_lag == 1, "R9", "ready lag after latch", mon_last_lag, 1);
        end
        chk(mon_bad_bhi == 0, "R4", "bit clock high width errors", mon_bad_bhi, 0);
        chk(mon_bad_setup == 0, "R5", "setup errors", mon_bad_setup, 0);
        chk(mon_bad_hold == 0, "R5", "hold errors", mon_bad_hold, 0);
        chk(mon_bad_ready == 0, "R7", "ready high while busy", mon_bad_ready, 0);

        // Request raised while busy is ignored
        p0 = mon_pulses; n0 = mon_nbits;
        send(32'hCAFE_0001, 8'h3C);
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_freq = 32'h1111_2222; req_ctrl = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        wait_pulses(p0 + 1);
        repeat (300) @(negedge clk);
        #1;
        chk(mon_nbits - n0 == 40, "R7", "no extra bits after busy request", mon_nbits - n0, 40);
        chk(mon_pulses - p0 == 1, "R7", "no extra pulse after busy request", mon_pulses - p0, 1);
        chk(mon_latched == send_order(32'hCAFE_0001, 8'h3C), "R7", "taken word kept",
            mon_latched, send_order(32'hCAFE_0001, 8'h3C));
        chk(!bit_clk && !word_clk && req_ready, "R8", "idle lines low",
            {bit_clk, word_clk}, 0);

        // Back-to-back requests with valid held
        p0 = mon_pulses;
        @(negedge clk);
        req_valid = 1'b1; req_freq = 32'h0F0F_F0F0; req_ctrl = 8'h01;
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            if (!req_ready) break;
        end
        req_freq = 32'h8000_0001; req_ctrl = 8'h80;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk); #1;
            if (mon_pulses >= p0 + 1) break;
        end
        chk(mon_latched == send_order(32'h0F0F_F0F0, 8'h01), "R3", "first held word",
            mon_latched, send_order(32'h0F0F_F0F0, 8'h01));
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk); #1;
            if (mon_pulses >= p0 + 2) break;
        end
        req_valid = 1'b0;
        chk(mon_latched == send_order(32'h8000_0001, 8'h80), "R3", "second held word",
            mon_latched, send_order(32'h8000_0001, 8'h80));
        chk(mon_pulses - p0 == 2, "R6", "two pulses for two words", mon_pulses - p0, 2);
        wait_pulses(p0 + 2);
        repeat (300) @(negedge clk);
        chk(mon_pulses - p0 == 2, "R2", "no transfer without valid", mon_pulses - p0, 2);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        if (wd_hit) begin
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule